// File: doc/BRIEF.md
# Fractional Audio Cycle Budget Counter

This block keeps the cycle budget of an audio processor tied to the timebase of a main processor whose scanline has been stretched to a whole number of host cycles. The main side reports each elapsed master clock on `mclk_tick` and the end of every scanline on `line_end`. Each scanline is implemented 6/16 of a master clock longer than ideal. To cancel that error, a 4-bit fractional accumulator adds 6 at each line end and, on every carry out, grants one extra master clock of credit.

Master clock credits pass through an integer divider, 21 by default. Each full quotient makes one audio cycle owed to the audio side. The audio side takes owed cycles through a valid/ready pair:
- `run_valid` is high while at least one cycle is owed.
- Each cycle in which `run_ready` is high while `run_valid` is high takes exactly one owed cycle.
- `run_ready` may stay low for as long as the audio side likes. Credits keep building up to a fixed ceiling. Past that ceiling they are dropped and a sticky overflow flag is raised.
- A sample strobe marks every 32nd audio cycle taken.

Top module: `audio_sync_counter`

## Requirements
- R1: After reset `owed` is 0, `run_valid` is 0, `owed_ovf` is 0 and `sample_tick` is 0.
- R2: A cycle with `mclk_tick` high is one master credit. For every DIVISOR (default 21) master credits, `owed` rises by one in the cycle after the credit that completes the quotient.
- R3: Each `line_end` adds 6 to a 4-bit accumulator that starts at 0. A carry out of bit 3 grants one extra master credit in that same cycle, and the remainder is kept. From reset, 55 line ends alone leave `owed` at 0, and the 56th makes it 1.
- R4: `run_valid` is high exactly when `owed` is nonzero. A cycle with `run_valid` and `run_ready` both high lowers `owed` by one in the next cycle, unless a credit completes in the same cycle.
- R5: `run_ready` while `owed` is 0 has no effect: `owed` stays 0 and never wraps.
- R6: `owed` never exceeds OWED_MAX (default 15). An audio cycle earned while `owed` is OWED_MAX and nothing is taken is dropped and sets `owed_ovf`. `owed_ovf` stays high until reset.
- R7: `sample_tick` is a one-cycle pulse, high in the cycle after every 32nd accepted take counted from reset.
- R8: When an audio cycle is earned and one is taken in the same cycle, `owed` is unchanged. This holds at OWED_MAX too, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_tick | input | 1 | One master clock elapsed on the main side |
| line_end | input | 1 | Scanline end strobe |
| run_valid | output | 1 | At least one audio cycle is owed |
| run_ready | input | 1 | Audio side takes one owed cycle |
| owed | output | 4 | Count of audio cycles owed |
| sample_tick | output | 1 | Pulse after every 32nd cycle taken |
| owed_ovf | output | 1 | Sticky: credit lost at the ceiling |

## Verification
The stimulus first uses master ticks alone, which isolates the divide ratio. Line ends alone come next, where the count after 55 and 56 lines shows whether the carry cadence of the fractional accumulator is right. Mixed ticks, line ends and steady or sparse takes then show up timing slips between earning and spending, and the 32-take sample cadence. Directed runs drive `owed` to exactly the ceiling and then overflow it, spend it while it is empty, and spend it at the ceiling while a credit arrives. These runs tell saturation apart from wrap-around, and a simultaneous earn and take apart from a lost credit.

// File: rtl/acs_pkg.sv
package acs_pkg;
  parameter int ACS_FRAC_W     = 4;
  parameter int ACS_FRAC_STEP  = 6;
  parameter int ACS_DIVISOR    = 21;
  parameter int ACS_OWED_MAX   = 15;
  parameter int ACS_SAMPLE_LEN = 32;

  // master credits that can arrive in one cycle: tick plus correction
  typedef logic [1:0] credit_t;
endpackage

// File: rtl/acs_frac_accum.sv
module acs_frac_accum #(
  parameter int FRAC_W = acs_pkg::ACS_FRAC_W,
  parameter int STEP   = acs_pkg::ACS_FRAC_STEP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end,
  output logic extra
);
  localparam logic [FRAC_W:0] STEP_V = (FRAC_W+1)'(STEP);

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc} + STEP_V;
    extra = line_end & sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        acc <= '0;
    else if (line_end) acc <= sum[FRAC_W-1:0];
  end

  AST_FRAC_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    extra |-> line_end); // R3
  AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(acc)); // R3
endmodule

// File: rtl/acs_credit_divider.sv
module acs_credit_divider #(
  parameter int DIVISOR = acs_pkg::ACS_DIVISOR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_tick,
  input  logic extra,
  output logic earn
);
  import acs_pkg::*;
  // DIVISOR must be at least 2 so two credits in a cycle earn at most once
  localparam int CNT_W = $clog2(DIVISOR + 2);
  localparam logic [CNT_W-1:0] DIV_V = CNT_W'(DIVISOR);

  credit_t          credits;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    credits = {1'b0, mclk_tick} + {1'b0, extra};
    nxt     = cnt + CNT_W'(credits);
    earn    = (nxt >= DIV_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (earn) cnt <= nxt - DIV_V;
    else           cnt <= nxt;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < DIV_V); // R2
  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_tick && !extra) |-> !earn); // R2
endmodule

// File: rtl/acs_owed_ledger.sv
module acs_owed_ledger #(
  parameter int OWED_MAX = acs_pkg::ACS_OWED_MAX,
  parameter int OWED_W   = $clog2(OWED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              earn,
  input  logic              run_ready,
  output logic [OWED_W-1:0] owed,
  output logic              run_valid,
  output logic              take,
  output logic              ovf
);
  localparam logic [OWED_W-1:0] MAX_V = OWED_W'(OWED_MAX);

  logic at_max;

  always_comb begin
    run_valid = (owed != '0);
    take      = run_valid & run_ready;
    at_max    = (owed == MAX_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
      ovf  <= 1'b0;
    end else begin
      if (earn && !take) begin
        if (at_max) ovf  <= 1'b1;
        else        owed <= owed + 1'b1;
      end else if (take && !earn) begin
        owed <= owed - 1'b1;
      end
    end
  end

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= MAX_V); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == '0 && !earn) |=> owed == '0); // R5
  AST_TAKE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !earn) |=> owed == $past(owed) - 1'b1); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && earn) |=> $stable(owed) && ovf == $past(ovf)); // R8
endmodule

// File: rtl/acs_sample_pacer.sv
module acs_sample_pacer #(
  parameter int SAMPLE_LEN = acs_pkg::ACS_SAMPLE_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic sample_tick
);
  localparam int SW = $clog2(SAMPLE_LEN);
  localparam logic [SW-1:0] LAST = SW'(SAMPLE_LEN - 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      sample_tick <= 1'b0;
    end else begin
      sample_tick <= take && (cnt == LAST);
      if (take) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R7
  AST_SAMPLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_tick) |-> $past(take)); // R7
endmodule

// File: rtl/audio_sync_counter.sv
module audio_sync_counter #(
  parameter int FRAC_W     = acs_pkg::ACS_FRAC_W,
  parameter int FRAC_STEP  = acs_pkg::ACS_FRAC_STEP,
  parameter int DIVISOR    = acs_pkg::ACS_DIVISOR,
  parameter int OWED_MAX   = acs_pkg::ACS_OWED_MAX,
  parameter int SAMPLE_LEN = acs_pkg::ACS_SAMPLE_LEN,
  localparam int OWED_W    = $clog2(OWED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_tick,
  input  logic              line_end,
  output logic              run_valid,
  input  logic              run_ready,
  output logic [OWED_W-1:0] owed,
  output logic              sample_tick,
  output logic              owed_ovf
);
  logic extra;
  logic earn;
  logic take;

  acs_frac_accum #(.FRAC_W(FRAC_W), .STEP(FRAC_STEP)) u_frac (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .extra(extra));

  acs_credit_divider #(.DIVISOR(DIVISOR)) u_div (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .extra(extra), .earn(earn));

  acs_owed_ledger #(.OWED_MAX(OWED_MAX), .OWED_W(OWED_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .earn(earn), .run_ready(run_ready),
    .owed(owed), .run_valid(run_valid), .take(take), .ovf(owed_ovf));

  acs_sample_pacer #(.SAMPLE_LEN(SAMPLE_LEN)) u_pacer (
    .clk(clk), .rst_n(rst_n), .take(take), .sample_tick(sample_tick));

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid == (owed != '0)); // R4
endmodule

// File: tb/audio_sync_counter_tb_top.sv
module audio_sync_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_tick = 1'b0;
  logic line_end = 1'b0;
  logic run_ready = 1'b0;
  logic run_valid;
  logic [3:0] owed;
  logic sample_tick;
  logic owed_ovf;

  always #5 clk = ~clk;

  audio_sync_counter dut_i (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .line_end(line_end),
    .run_valid(run_valid), .run_ready(run_ready), .owed(owed),
    .sample_tick(sample_tick), .owed_ovf(owed_ovf));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural expectation built from the requirements
  int m_acc, m_div, m_owed, m_samp;
  bit m_ovf, m_stick;

  // stimulus table: cycles, tick period, line-end period, take period (0 = never)
  localparam int ROWS = 7;
  localparam int T_CYC[ROWS]  = '{50, 40, 300, 400, 100, 2000, 600};
  localparam int T_TICK[ROWS] = '{1, 1, 1, 1, 0, 1, 2};
  localparam int T_LINE[ROWS] = '{0, 5, 0, 0, 0, 3, 7};
  localparam int T_TAKE[ROWS] = '{0, 0, 1, 0, 1, 1, 3};
  string row_tag[ROWS];

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mclk_tick = 0; line_end = 0; run_ready = 0;
    m_acc = 0; m_div = 0; m_owed = 0; m_samp = 0; m_ovf = 0; m_stick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input string tag, input bit t, input bit le, input bit c);
    int credits;
    bit earn, take;
    mclk_tick = t; line_end = le; run_ready = c;
    credits = t ? 1 : 0;
    if (le) begin
      m_acc += 6;
      if (m_acc >= 16) begin m_acc -= 16; credits++; end
    end
    m_div += credits;
    earn = (m_div >= 21);
    if (earn) m_div -= 21;
    take = c && (m_owed > 0);
    if (earn && !take) begin
      if (m_owed == 15) m_ovf = 1; else m_owed++;
    end else if (take && !earn) m_owed--;
    m_stick = 0;
    if (take) begin
      m_samp++;
      if (m_samp == 32) begin m_samp = 0; m_stick = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " owed"}, int'(owed), m_owed);
    check({tag, " R4 run_valid"}, int'(run_valid), (m_owed != 0) ? 1 : 0);
    check({tag, " R6 owed_ovf"}, int'(owed_ovf), int'(m_ovf));
    check({tag, " R7 sample_tick"}, int'(sample_tick), int'(m_stick));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    row_tag[0] = "R2 ticks";
    row_tag[1] = "R3 ticks+lines";
    row_tag[2] = "R4 drain";
    row_tag[3] = "R6 saturate";
    row_tag[4] = "R5 empty take";
    row_tag[5] = "R7 mixed";
    row_tag[6] = "R8 sparse";

    // R1: reset state
    do_reset();
    @(negedge clk);
    check("R1 owed", int'(owed), 0);
    check("R1 run_valid", int'(run_valid), 0);
    check("R1 owed_ovf", int'(owed_ovf), 0);
    check("R1 sample_tick", int'(sample_tick), 0);

    // table walk
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < T_CYC[r]; i++) begin
        step(row_tag[r],
             (T_TICK[r] != 0) && (i % (T_TICK[r] == 0 ? 1 : T_TICK[r]) == 0),
             (T_LINE[r] != 0) && (i % (T_LINE[r] == 0 ? 1 : T_LINE[r]) == T_LINE[r] - 1),
             (T_TAKE[r] != 0) && (i % (T_TAKE[r] == 0 ? 1 : T_TAKE[r]) == 0));
      end
    end

    // R2: exactly 21 ticks make one owed cycle
    do_reset();
    for (int i = 0; i < 20; i++) step("R2 div", 1, 0, 0);
    check("R2 owed after 20 ticks", int'(owed), 0);
    step("R2 div", 1, 0, 0);
    check("R2 owed after 21 ticks", int'(owed), 1);

    // R3: 55 line ends alone owe nothing, the 56th owes one
    do_reset();
    for (int i = 0; i < 55; i++) step("R3 lines", 0, 1, 0);
    check("R3 owed after 55 lines", int'(owed), 0);
    step("R3 lines", 0, 1, 0);
    check("R3 owed after 56 lines", int'(owed), 1);

    // R5: takes while empty are ignored
    do_reset();
    for (int i = 0; i < 5; i++) step("R5 empty", 0, 0, 1);
    check("R5 owed stays 0", int'(owed), 0);
    for (int i = 0; i < 21; i++) step("R5 refill", 1, 0, 0);
    check("R5 owed after refill", int'(owed), 1);

    // R8 and R6: fill to the ceiling exactly, earn and take together, then overflow
    do_reset();
    for (int i = 0; i < 315; i++) step("R6 fill", 1, 0, 0);
    check("R6 owed at ceiling", int'(owed), 15);
    check("R6 no ovf yet", int'(owed_ovf), 0);
    for (int i = 0; i < 20; i++) step("R8 hold", 1, 0, 0);
    step("R8 earn+take", 1, 0, 1);
    check("R8 owed unchanged", int'(owed), 15);
    check("R8 no ovf", int'(owed_ovf), 0);
    for (int i = 0; i < 21; i++) step("R6 over", 1, 0, 0);
    check("R6 owed capped", int'(owed), 15);
    check("R6 ovf set", int'(owed_ovf), 1);
    for (int i = 0; i < 16; i++) step("R6 drain", 0, 0, 1);
    check("R6 ovf sticky", int'(owed_ovf), 1);
    check("R5 drained", int'(owed), 0);

    finish_run();
  end
endmodule